// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block holds the 32-bit accumulator of a fixed-point signal-processing datapath and applies one operation per cycle to it. Each operation pairs the accumulator with a 32-bit operand. The available operations are load, add, subtract, the three bitwise logic operations, and a normalize test. Instruction decode, branch logic and the memory path are outside the block. They deliver an operation code, an already aligned operand, and a marker that says whether that operand was shifted left by sixteen places.

The unit keeps four status bits. The carry bit follows additions and subtractions, but its update is restricted when the sixteen-place marker is set. The overflow bit is sticky. The saturation-mode bit decides whether a signed overflow wraps or clamps the accumulator. The test bit records the result of the normalize test. Mode strobes set or clear the saturation mode, and a clear strobe empties the overflow bit.

Top module: `accu_unit`

## Requirements
- R1: After reset the accumulator is 0, carry is 1, overflow is 0, saturation mode is 0 and the test bit is 0.
- R2: Operation codes are 0 load, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 normalize test and 7 no change. Load copies the operand into the accumulator. The logic codes combine the accumulator with the operand bit by bit. None of these four changes carry or overflow.
- R3: When the sixteen-place marker is low, carry after an add equals the unsigned carry out. Carry after a subtract is 1 when there was no borrow (accumulator ≥ operand, unsigned) and 0 when there was one.
- R4: When the sixteen-place marker is high, an add sets carry only if it produced a carry out and otherwise leaves carry unchanged. A subtract clears carry only if it borrowed and otherwise leaves carry unchanged.
- R5: Overflow is set by any add or subtract whose signed result does not fit in 32 bits. It stays set until reset or a clear strobe. If an overflow occurs in the same cycle as a clear strobe, the overflow wins.
- R6: With saturation mode 0, the accumulator receives the low 32 bits of an overflowing result.
- R7: With saturation mode 1, an overflowing result is replaced by 32'h7FFFFFFF if it overflowed positively and by 32'h80000000 if it overflowed negatively. An operation uses the mode value held before that edge.
- R8: The set strobe sets saturation mode and the clear strobe clears it. When both are high, clear wins.
- R9: The normalize test loads the test bit with the XOR of accumulator bits 31 and 30, as they stand before the edge, and leaves the accumulator unchanged.
- R10: While the operation-valid input is low, the accumulator, carry and test bit keep their values whatever the code and operand are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Applies op_code on this edge |
| op_code | input | 3 | Operation select (see R2) |
| operand | input | 32 | Aligned operand |
| hi_shift | input | 1 | Operand was shifted left by 16 |
| sat_set | input | 1 | Set saturation mode |
| sat_clr | input | 1 | Clear saturation mode |
| ovf_clr | input | 1 | Clear sticky overflow |
| acc | output | 32 | Accumulator |
| carry | output | 1 | Carry flag |
| ovf | output | 1 | Sticky overflow flag |
| sat_mode | output | 1 | Saturation mode |
| tc | output | 1 | Test/control flag |

## Verification
The hardest cases to reach are the restricted carry updates. A shifted add or subtract only shows its effect when the carry bit already holds the value the operation may not change. That prior value depends on whatever arithmetic ran before. The stimulus sweeps every pairing of eight boundary operands for both add and subtract, with and without the shift marker and in both saturation modes. Every operation is preceded by a load, and the load keeps the carry left behind by the previous pairing, so the carry arrives at both of its values across the sweep. Overflow clear strobes are placed in the same cycle as overflowing operations to test which one takes priority.

// File: rtl/accu_pkg.sv
package accu_pkg;
  parameter int ACC_W = 32;

  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_NORM = 3'd6,
    OP_HOLD = 3'd7
  } op_t;
endpackage

// File: rtl/accu_adder.sv
module accu_adder #(
  parameter int W = accu_pkg::ACC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf_evt,
  output logic         ovf_pos
);
  typedef struct packed {
    logic [W-1:0] s;
    logic         c;
    logic         v;
  } add_res_t;

  // subtraction is a + ~b + 1; carry out doubles as "no borrow"
  function automatic add_res_t add_core(input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic         neg);
    add_res_t     r;
    logic [W-1:0] yy;
    logic [W:0]   ext;
    yy  = neg ? ~y : y;
    ext = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, neg};
    r.s = ext[W-1:0];
    r.c = ext[W];
    r.v = (x[W-1] == yy[W-1]) && (ext[W-1] != x[W-1]);
    return r;
  endfunction

  add_res_t res;
  always_comb begin
    res     = add_core(a, b, sub);
    sum     = res.s;
    cout    = res.c;
    ovf_evt = res.v;
    ovf_pos = ~a[W-1];
  end
endmodule

// File: rtl/accu_flags.sv
module accu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic is_add,
  input  logic is_sub,
  input  logic is_norm,
  input  logic hi_shift,
  input  logic cout,
  input  logic ovf_evt,
  input  logic norm_bit,
  input  logic sat_set,
  input  logic sat_clr,
  input  logic ovf_clr,
  output logic c_q,
  output logic ov_q,
  output logic ovm_q,
  output logic tc_q
);
  logic arith;
  logic c_nxt;
  assign arith = upd && (is_add || is_sub);

  always_comb begin
    c_nxt = c_q;
    if (arith) begin
      if (!hi_shift)            c_nxt = cout;
      else if (is_add && cout)  c_nxt = 1'b1;
      else if (is_sub && !cout) c_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= 1'b1;
      ov_q  <= 1'b0;
      ovm_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      c_q <= c_nxt;
      if (arith && ovf_evt) ov_q <= 1'b1;
      else if (ovf_clr)     ov_q <= 1'b0;
      if (sat_clr)      ovm_q <= 1'b0;
      else if (sat_set) ovm_q <= 1'b1;
      if (upd && is_norm) tc_q <= norm_bit;
    end
  end

  // R5
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !ovf_clr) |=> ov_q);
  // R4
  hs_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arith && is_add && hi_shift && c_q) |=> c_q);
  // R4
  hs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arith && is_sub && hi_shift && !c_q) |=> !c_q);
  // R8
  mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !ovm_q);
endmodule

// File: rtl/accu_unit.sv
module accu_unit #(
  parameter int W = accu_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic         hi_shift,
  input  logic         sat_set,
  input  logic         sat_clr,
  input  logic         ovf_clr,
  output logic [W-1:0] acc,
  output logic         carry,
  output logic         ovf,
  output logic         sat_mode,
  output logic         tc
);
  import accu_pkg::*;

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  op_t          op;
  logic [W-1:0] acc_q, acc_nxt, sum;
  logic         cout, ovf_evt, ovf_pos;
  logic         is_add, is_sub, is_norm, arith_ovf;

  assign op      = op_t'(op_code);
  assign is_add  = (op == OP_ADD);
  assign is_sub  = (op == OP_SUB);
  assign is_norm = (op == OP_NORM);

  accu_adder #(.W(W)) u_add (
    .a(acc_q), .b(operand), .sub(is_sub),
    .sum(sum), .cout(cout), .ovf_evt(ovf_evt), .ovf_pos(ovf_pos)
  );

  assign arith_ovf = (is_add || is_sub) && ovf_evt;

  always_comb begin
    acc_nxt = acc_q;
    unique case (op)
      OP_LOAD:        acc_nxt = operand;
      OP_ADD, OP_SUB: begin
        if (ovf_evt && sat_mode) acc_nxt = ovf_pos ? MAX_POS : MAX_NEG;
        else                     acc_nxt = sum;
      end
      OP_AND:         acc_nxt = acc_q & operand;
      OP_OR:          acc_nxt = acc_q | operand;
      OP_XOR:         acc_nxt = acc_q ^ operand;
      default:        acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (op_valid) acc_q <= acc_nxt;
  end

  accu_flags u_flg (
    .clk(clk), .rst_n(rst_n), .upd(op_valid),
    .is_add(is_add), .is_sub(is_sub), .is_norm(is_norm),
    .hi_shift(hi_shift), .cout(cout), .ovf_evt(ovf_evt),
    .norm_bit(acc_q[W-1] ^ acc_q[W-2]),
    .sat_set(sat_set), .sat_clr(sat_clr), .ovf_clr(ovf_clr),
    .c_q(carry), .ov_q(ovf), .ovm_q(sat_mode), .tc_q(tc)
  );

  assign acc = acc_q;

  // R7
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && arith_ovf && sat_mode) |=> (acc_q == MAX_POS || acc_q == MAX_NEG));
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && arith_ovf) |=> ovf);
  // R9
  norm_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_norm) |=> (tc == ($past(acc_q[W-1]) ^ $past(acc_q[W-2]))) && $stable(acc_q));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc_q) && $stable(tc));
endmodule

// File: tb/sim_accu_unit.sv
`timescale 1ns/1ps
module sim_accu_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd7;
  logic [31:0] operand = '0;
  logic        hi_shift = 1'b0, sat_set = 1'b0, sat_clr = 1'b0, ovf_clr = 1'b0;
  logic [31:0] acc;
  logic        carry, ovf, sat_mode, tc;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_acc = '0;
  logic        m_c = 1'b1, m_ov = 1'b0, m_ovm = 1'b0, m_tc = 1'b0;

  always #2.5 clk = ~clk;

  accu_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .hi_shift(hi_shift), .sat_set(sat_set),
    .sat_clr(sat_clr), .ovf_clr(ovf_clr), .acc(acc), .carry(carry),
    .ovf(ovf), .sat_mode(sat_mode), .tc(tc)
  );

  task automatic compare(input string tag);
    n_chk++;
    if (acc !== m_acc || carry !== m_c || ovf !== m_ov || sat_mode !== m_ovm || tc !== m_tc) begin
      n_bad++;
      $display("FAIL %s: acc=%h c=%b ov=%b ovm=%b tc=%b expected acc=%h c=%b ov=%b ovm=%b tc=%b",
               tag, acc, carry, ovf, sat_mode, tc, m_acc, m_c, m_ov, m_ovm, m_tc);
    end
  endtask

  // reference: wide signed arithmetic and unsigned comparison
  task automatic model(input logic v, input logic [2:0] op, input logic [31:0] b,
                       input logic hs, input logic ss, input logic sc, input logic oc);
    longint sa, sb, s;
    logic   cy, vo;
    sa = longint'($signed(m_acc));
    sb = longint'($signed(b));
    if (v && (op == 3'd1 || op == 3'd2)) begin
      if (op == 3'd1) begin
        s  = sa + sb;
        cy = ({1'b0, m_acc} + {1'b0, b}) > 33'h0_FFFF_FFFF;
      end else begin
        s  = sa - sb;
        cy = (m_acc >= b);
      end
      vo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      if (!hs) m_c = cy;
      else if (op == 3'd1 && cy) m_c = 1'b1;
      else if (op == 3'd2 && !cy) m_c = 1'b0;
      if (vo && m_ovm) m_acc = (s > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
      else m_acc = s[31:0];
      if (vo) m_ov = 1'b1;
      else if (oc) m_ov = 1'b0;
    end else begin
      if (oc) m_ov = 1'b0;
      if (v) begin
        case (op)
          3'd0: m_acc = b;
          3'd3: m_acc = m_acc & b;
          3'd4: m_acc = m_acc | b;
          3'd5: m_acc = m_acc ^ b;
          3'd6: m_tc  = m_acc[31] ^ m_acc[30];
          default: ;
        endcase
      end
    end
    if (sc) m_ovm = 1'b0;
    else if (ss) m_ovm = 1'b1;
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] b,
                      input logic hs, input logic ss, input logic sc, input logic oc,
                      input string tag);
    @(negedge clk);
    op_valid = v; op_code = op; operand = b; hi_shift = hs;
    sat_set = ss; sat_clr = sc; ovf_clr = oc;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd7; hi_shift = 1'b0;
    sat_set = 1'b0; sat_clr = 1'b0; ovf_clr = 1'b0;
    model(v, op, b, hs, ss, sc, oc);
    compare(tag);
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h0001_0000;
      6: return 32'hFFFF_0000;
      default: return 32'h5A5A_A5A5;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic hs, input logic ovm);
    if (op == 3'd1 || op == 3'd2) begin
      if (hs) return ovm ? "R4 R5 R7" : "R4 R5 R6";
      return ovm ? "R3 R5 R7" : "R3 R5 R6";
    end
    if (op == 3'd6) return "R9";
    return "R2";
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    // R8: both strobes, clear wins
    step(1'b0, 3'd7, '0, 1'b0, 1'b1, 1'b1, 1'b0, "R8 both");
    step(1'b0, 3'd7, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 set");
    step(1'b0, 3'd7, '0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 clr");
    for (int m = 0; m < 2; m++) begin
      if (m == 1) step(1'b0, 3'd7, '0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 set");
      for (int op = 1; op < 7; op++)
        for (int h = 0; h < 2; h++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              if (op != 1 && op != 2 && h == 1) continue;
              step(1'b1, 3'd0, pick(i), 1'b0, 1'b0, 1'b0, 1'b0, "R2 load");
              // clear strobe coincides with the operation on some pairings (R5 priority)
              step(1'b1, 3'(op), pick(j), 1'(h), 1'b0, 1'b0, 1'(j == 3 || j == 6),
                   tag_of(3'(op), 1'(h), 1'(m)));
              if (j == 5) step(1'b0, 3'd7, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 clear");
              // R10: idle cycle with live-looking inputs
              if (j == 7) step(1'b0, 3'(op), pick(j), 1'(h), 1'b0, 1'b0, 1'b0, "R10 idle");
            end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule